// File: doc/BRIEF.md
# Lockable control register bank

This block is the register file that sits behind a frame-based serial port on a motor-driver style chip. An upstream shifter decodes each frame into a one-cycle access strobe with a direction, an 8-bit address and an 8-bit write byte. The bank answers reads with a registered byte. It holds an identity byte, a fault summary, two status views, a command register, a register that overrides the driver input pins, and four configuration bytes.

Fault and status events arrive on raw input wires. Fault events are latched as individual sticky bits. These bits stay set until software writes the clear command. The summary byte reports each fault class and an OR of all of them, and an active-low fault pin mirrors that OR. Two code-based lock fields with opposite polarity protect the pin-override byte and the configuration group. An access to any address outside the map is blocked and raises a sticky error flag.

Top module: `ctl_regbank`

## Requirements
- R1: After reset the bank reads as follows. 00h returns the ID_VALUE parameter (default A1h). 01h=60h, 08h=09h, 09h=0Ch, 0Ah=10h, 0Bh=00h, 0Ch=40h, 0Dh=04h. `fault_n` is low because the power-on flag (01h bit 6) starts set.
- R2: A read or write to an address outside 00h–03h and 08h–0Dh has no effect on any register. A read of such an address returns 00h. From the next cycle the access error flag (01h bit 7) is set.
- R3: Bit 5 of 01h is the OR of bits 7, 6, 4, 3, 2, 1 and 0 of 01h, and `fault_n` is its inverse.
- R4: Writing 08h with bit 7 set clears every latched fault: 01h, and bits 7, 6 and 3:0 of 02h. The clear applies at the accepting edge, and 08h bit 7 always reads 0.
- R5: A fault event that is present in the same cycle as a clear stays latched.
- R6: Each fault event latches into its bit, and the bit holds after the event goes away. `ev_vmov` goes to 01h bit 4, `ev_vmuv` to bit 3, `ev_tsd` to bit 1. `ev_ocp[3:0]` goes to 02h bits 3:0, and 01h bit 2 is their OR. `ev_ola[0]` goes to 02h bit 7 and `ev_ola[1]` to 02h bit 6, and 01h bit 0 is their OR.
- R7: Live status reads are taken in the read cycle. In 02h, bit 5 is `st_itrip` and bit 4 is `st_active`. In 03h, bit 7 is `st_drvoff`, bit 4 is `st_active` and bit 0 is `st_olp`.
- R8: Register 09h accepts writes only while 08h bits 4:3 equal 10b, which also drives `ovr_unlocked` high. Any other code discards the write without setting the error flag. `ovr_bits` mirrors 09h bits 3:0.
- R9: The configuration bytes 0Ah–0Dh ignore writes while 08h bits 1:0 equal 10b, without setting the error flag. Any other code lets the writes in. `cfg_o[8*i+7:8*i]` mirrors register 0Ah+i.
- R10: Unimplemented bits read 0 and ignore writes. The writable masks are 08h=1Bh (plus the clear bit), 09h=0Fh, 0Ah=FFh, 0Bh=E7h, 0Ch=DFh and 0Dh=DFh.
- R11: Writes to 00h–03h are ignored and do not set the error flag.
- R12: `rd_data` changes only at an edge that accepts a read, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | One-cycle access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write byte |
| rd_data | output | 8 | Registered read byte |
| ev_vmov | input | 1 | Over-voltage event |
| ev_vmuv | input | 1 | Under-voltage event |
| ev_ocp | input | 4 | Over-current events, one per power switch |
| ev_tsd | input | 1 | Over-temperature event |
| ev_ola | input | 2 | Open-load events, one per output |
| st_itrip | input | 1 | Live current-regulation comparator |
| st_active | input | 1 | Live active-state indication |
| st_drvoff | input | 1 | Live level of the shut-off pin |
| st_olp | input | 1 | Live off-state diagnostic comparator |
| cfg_o | output | 32 | Configuration bytes 0Ah–0Dh, lowest address in the low byte |
| ovr_bits | output | 4 | Pin-override bits |
| ovr_unlocked | output | 1 | Pin-override register unlocked |
| fault_n | output | 1 | Active-low fault pin |

## Verification
Each access or event is registered at exactly one edge. A write or event shows in a read of the bank, on `cfg_o`, on `ovr_bits` and on `fault_n` just after the edge that accepted it. A read result is on `rd_data` just after the edge that takes the read strobe, and the error flag is visible one edge after the bad access. The bench drives every input on the falling edge and holds it across one rising edge. It samples on the next falling edge, so each check falls half a cycle after the edge that produced the value.

// File: rtl/ctl_regbank_pkg.sv
package ctl_regbank_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned N_CFG  = 4;

  localparam logic [ADDR_W-1:0] A_ID    = 8'h00;
  localparam logic [ADDR_W-1:0] A_SUM   = 8'h01;
  localparam logic [ADDR_W-1:0] A_STA   = 8'h02;
  localparam logic [ADDR_W-1:0] A_STB   = 8'h03;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'h08;
  localparam logic [ADDR_W-1:0] A_OVR   = 8'h09;
  localparam logic [ADDR_W-1:0] A_CFG0  = 8'h0A;

  localparam logic [DATA_W-1:0] CMD_MASK = 8'h1B;
  localparam logic [DATA_W-1:0] CMD_RST  = 8'h09;
  localparam logic [DATA_W-1:0] OVR_MASK = 8'h0F;
  localparam logic [DATA_W-1:0] OVR_RST  = 8'h0C;
  localparam logic [1:0]        KEY_CODE = 2'b10;

  // fault flag vector layout
  localparam int unsigned F_ERR = 0;
  localparam int unsigned F_POR = 1;
  localparam int unsigned F_OV  = 2;
  localparam int unsigned F_UV  = 3;
  localparam int unsigned F_OT  = 4;
  localparam int unsigned F_OC0 = 5;   // 4 bits
  localparam int unsigned F_OL0 = 9;   // 2 bits
  localparam int unsigned N_FLT = 11;

  function automatic logic [DATA_W-1:0] cfg_mask(input int unsigned idx);
    case (idx)
      0:       return 8'hFF;
      1:       return 8'hE7;
      default: return 8'hDF;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] cfg_rst(input int unsigned idx);
    case (idx)
      0:       return 8'h10;
      2:       return 8'h40;
      3:       return 8'h04;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/ctl_rst_sync.sv
module ctl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/ctl_maskreg.sv
module ctl_maskreg #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] MASK = '1,
  parameter logic [W-1:0] RST  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = (wdata & MASK) | (RST & ~MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else if (we) q <= q_d;
  end

  // R10: bits outside the mask never leave their reset value
  a_r10_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ((q & ~MASK) == (RST & ~MASK)));
  // R12-style hold: no write strobe, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/ctl_sticky.sv
module ctl_sticky #(
  parameter int unsigned  W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic         clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr) q_d = '0;
    q_d = q_d | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST;
    else        q <= q_d;
  end

  a_r4_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (q == '0));
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));
  a_r6_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
  import ctl_regbank_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'hA1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    acc_wr,
  input  logic [ADDR_W-1:0]       acc_addr,
  input  logic [DATA_W-1:0]       acc_wdata,
  output logic [DATA_W-1:0]       rd_data,
  input  logic                    ev_vmov,
  input  logic                    ev_vmuv,
  input  logic [3:0]              ev_ocp,
  input  logic                    ev_tsd,
  input  logic [1:0]              ev_ola,
  input  logic                    st_itrip,
  input  logic                    st_active,
  input  logic                    st_drvoff,
  input  logic                    st_olp,
  output logic [DATA_W*N_CFG-1:0] cfg_o,
  output logic [3:0]              ovr_bits,
  output logic                    ovr_unlocked,
  output logic                    fault_n
);
  logic              rst_ni;
  logic              wr_en, rd_en;
  logic              in_ro, in_rw, mapped;
  logic              clr_pulse, cfg_locked;
  logic [DATA_W-1:0] cmd_q, ovr_q;
  logic [DATA_W-1:0] cfg_arr [N_CFG];
  logic [N_FLT-1:0]  flt_set, flt_q;
  logic              any_flt;
  logic [DATA_W-1:0] sum_b, sta_b, stb_b, rd_next;

  ctl_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ni));

  // address decode
  always_comb begin
    in_ro  = (acc_addr <= A_STB);
    in_rw  = (acc_addr >= A_CMD) && (acc_addr < A_CFG0 + 8'(N_CFG));
    mapped = in_ro || in_rw;
    wr_en  = acc_en && acc_wr && in_rw;
    rd_en  = acc_en && !acc_wr;
  end

  assign clr_pulse = wr_en && (acc_addr == A_CMD) && acc_wdata[7];

  // command register (lock codes); clear bit is never stored
  ctl_maskreg #(.W(DATA_W), .MASK(CMD_MASK), .RST(CMD_RST)) u_cmd (
    .clk(clk), .rst_n(rst_ni),
    .we(wr_en && acc_addr == A_CMD),
    .wdata(acc_wdata), .q(cmd_q));

  assign ovr_unlocked = (cmd_q[4:3] == KEY_CODE);
  assign cfg_locked   = (cmd_q[1:0] == KEY_CODE);

  ctl_maskreg #(.W(DATA_W), .MASK(OVR_MASK), .RST(OVR_RST)) u_ovr (
    .clk(clk), .rst_n(rst_ni),
    .we(wr_en && acc_addr == A_OVR && ovr_unlocked),
    .wdata(acc_wdata), .q(ovr_q));

  assign ovr_bits = ovr_q[3:0];

  for (genvar gi = 0; gi < N_CFG; gi++) begin : g_cfg
    localparam logic [ADDR_W-1:0] ADR = A_CFG0 + 8'(gi);
    ctl_maskreg #(.W(DATA_W), .MASK(cfg_mask(gi)), .RST(cfg_rst(gi))) u_reg (
      .clk(clk), .rst_n(rst_ni),
      .we(wr_en && acc_addr == ADR && !cfg_locked),
      .wdata(acc_wdata), .q(cfg_arr[gi]));
    assign cfg_o[gi*DATA_W +: DATA_W] = cfg_arr[gi];
  end

  // fault latches
  always_comb begin
    flt_set                   = '0;
    flt_set[F_ERR]            = acc_en && !mapped;
    flt_set[F_OV]             = ev_vmov;
    flt_set[F_UV]             = ev_vmuv;
    flt_set[F_OT]             = ev_tsd;
    flt_set[F_OC0 +: 4]       = ev_ocp;
    flt_set[F_OL0 +: 2]       = ev_ola;
  end

  ctl_sticky #(.W(N_FLT), .RST(N_FLT'(1) << F_POR)) u_flt (
    .clk(clk), .rst_n(rst_ni), .set(flt_set), .clr(clr_pulse), .q(flt_q));

  assign any_flt = |flt_q;
  assign fault_n = !any_flt;

  // read views
  always_comb begin
    sum_b = {flt_q[F_ERR], flt_q[F_POR], any_flt, flt_q[F_OV], flt_q[F_UV],
             |flt_q[F_OC0 +: 4], flt_q[F_OT], |flt_q[F_OL0 +: 2]};
    sta_b = {flt_q[F_OL0], flt_q[F_OL0+1], st_itrip, st_active, flt_q[F_OC0 +: 4]};
    stb_b = {st_drvoff, 2'b00, st_active, 3'b000, st_olp};
  end

  always_comb begin
    rd_next = '0;
    case (acc_addr)
      A_ID:    rd_next = ID_VALUE;
      A_SUM:   rd_next = sum_b;
      A_STA:   rd_next = sta_b;
      A_STB:   rd_next = stb_b;
      A_CMD:   rd_next = cmd_q;
      A_OVR:   rd_next = ovr_q;
      default: begin
        for (int i = 0; i < N_CFG; i++)
          if (acc_addr == A_CFG0 + 8'(i)) rd_next = cfg_arr[i];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end

  a_r2_err_flag: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_en && !mapped) |=> !fault_n);
  a_r3_pin_matches_summary: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && acc_addr == A_SUM) |=> (rd_data[5] == !fault_n));
  a_r8_ovr_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_en && acc_wr && acc_addr == A_OVR && !ovr_unlocked) |=> $stable(ovr_bits));
  a_r9_cfg_locked: assert property (@(posedge clk) disable iff (!rst_ni)
    (acc_en && acc_wr && acc_addr != A_CMD && cfg_locked) |=> $stable(cfg_o));
  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/ctl_regbank_test.sv
module ctl_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [7:0]  acc_addr, acc_wdata, rd_data;
  logic        ev_vmov, ev_vmuv, ev_tsd;
  logic [3:0]  ev_ocp;
  logic [1:0]  ev_ola;
  logic        st_itrip, st_active, st_drvoff, st_olp;
  logic [31:0] cfg_o;
  logic [3:0]  ovr_bits;
  logic        ovr_unlocked, fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  ctl_regbank uut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .rd_data(rd_data),
    .ev_vmov(ev_vmov), .ev_vmuv(ev_vmuv), .ev_ocp(ev_ocp), .ev_tsd(ev_tsd),
    .ev_ola(ev_ola), .st_itrip(st_itrip), .st_active(st_active),
    .st_drvoff(st_drvoff), .st_olp(st_olp), .cfg_o(cfg_o),
    .ovr_bits(ovr_bits), .ovr_unlocked(ovr_unlocked), .fault_n(fault_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    @(negedge clk);
    acc_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, {24'd0, v}, {24'd0, exp});
  endtask

  task automatic clear_all();
    wr(8'h08, 8'h80 | 8'h09);
  endtask

  task automatic t_reset();
    rd_chk("R1 id", 8'h00, 8'hA1);
    chk("R1 fault_n", {31'd0, fault_n}, 32'd0);
    rd_chk("R1 summary", 8'h01, 8'h60);
    rd_chk("R1 cmd", 8'h08, 8'h09);
    rd_chk("R1 ovr", 8'h09, 8'h0C);
    rd_chk("R1 cfg0", 8'h0A, 8'h10);
    rd_chk("R1 cfg1", 8'h0B, 8'h00);
    rd_chk("R1 cfg2", 8'h0C, 8'h40);
    rd_chk("R1 cfg3", 8'h0D, 8'h04);
    chk("R9 cfg_o reset", cfg_o, 32'h0440_0010);
  endtask

  task automatic t_clear();
    clear_all();
    chk("R4 fault_n released", {31'd0, fault_n}, 32'd1);
    rd_chk("R4 summary cleared", 8'h01, 8'h00);
    rd_chk("R4 clear bit reads 0", 8'h08, 8'h09);
  endtask

  task automatic t_unmapped();
    rd_chk("R2 unmapped read", 8'h05, 8'h00);
    rd_chk("R2 error flag", 8'h01, 8'hA0);
    chk("R3 fault_n on error", {31'd0, fault_n}, 32'd0);
    clear_all();
    wr(8'hFF, 8'h55);
    rd_chk("R2 unmapped write", 8'h01, 8'hA0);
    wr(8'h0E, 8'h00);
    rd_chk("R2 cfg intact", 8'h0A, 8'h10);
    clear_all();
  endtask

  task automatic t_events();
    ev_vmov = 1'b1; @(negedge clk); ev_vmov = 1'b0;
    rd_chk("R6 R3 vmov", 8'h01, 8'h30);
    ev_ocp = 4'b0100; @(negedge clk); ev_ocp = 4'b0000;
    rd_chk("R6 ocp status", 8'h02, 8'h04);
    ev_ola = 2'b10; @(negedge clk); ev_ola = 2'b00;
    rd_chk("R6 ola status", 8'h02, 8'h44);
    ev_ola = 2'b01; @(negedge clk); ev_ola = 2'b00;
    rd_chk("R6 ola out1", 8'h02, 8'hC4);
    ev_tsd = 1'b1; @(negedge clk); ev_tsd = 1'b0;
    ev_vmuv = 1'b1; @(negedge clk); ev_vmuv = 1'b0;
    rd_chk("R6 summary all", 8'h01, 8'h3F);
    clear_all();
    rd_chk("R4 status cleared", 8'h02, 8'h00);
    rd_chk("R4 summary cleared", 8'h01, 8'h00);
  endtask

  task automatic t_priority();
    ev_tsd = 1'b1;
    clear_all();
    ev_tsd = 1'b0;
    rd_chk("R5 event beats clear", 8'h01, 8'h22);
    clear_all();
  endtask

  task automatic t_status();
    st_itrip = 1'b1; st_active = 1'b1;
    rd_chk("R7 status a live", 8'h02, 8'h30);
    st_drvoff = 1'b1; st_olp = 1'b1;
    rd_chk("R7 status b live", 8'h03, 8'h91);
    st_itrip = 1'b0; st_active = 1'b0; st_drvoff = 1'b0; st_olp = 1'b0;
    rd_chk("R7 status b low", 8'h03, 8'h00);
    rd_chk("R7 no latch", 8'h01, 8'h00);
  endtask

  task automatic t_ovr();
    wr(8'h09, 8'h03);
    rd_chk("R8 locked write dropped", 8'h09, 8'h0C);
    chk("R8 ovr_bits locked", {28'd0, ovr_bits}, 32'hC);
    rd_chk("R8 no error", 8'h01, 8'h00);
    wr(8'h08, 8'h11);
    chk("R8 unlocked flag", {31'd0, ovr_unlocked}, 32'd1);
    rd_chk("R8 cmd code", 8'h08, 8'h11);
    wr(8'h09, 8'hF5);
    rd_chk("R10 ovr mask", 8'h09, 8'h05);
    chk("R8 ovr_bits", {28'd0, ovr_bits}, 32'h5);
    wr(8'h08, 8'h19);
    chk("R8 relocked", {31'd0, ovr_unlocked}, 32'd0);
    wr(8'h09, 8'h0A);
    rd_chk("R8 relock drop", 8'h09, 8'h05);
  endtask

  task automatic t_cfg();
    wr(8'h0B, 8'hFF);
    rd_chk("R10 cfg1 mask", 8'h0B, 8'hE7);
    wr(8'h0C, 8'hFF);
    rd_chk("R10 cfg2 mask", 8'h0C, 8'hDF);
    wr(8'h0D, 8'h00);
    wr(8'h0A, 8'hAB);
    chk("R9 cfg_o", cfg_o, 32'h00DF_E7AB);
    wr(8'h08, 8'h1A);
    wr(8'h0A, 8'h00);
    rd_chk("R9 locked cfg", 8'h0A, 8'hAB);
    rd_chk("R9 no error", 8'h01, 8'h00);
    wr(8'h08, 8'h1B);
    wr(8'h0A, 8'h55);
    rd_chk("R9 unlocked cfg", 8'h0A, 8'h55);
    wr(8'h08, 8'hFF);
    rd_chk("R10 cmd mask", 8'h08, 8'h1B);
  endtask

  task automatic t_ro_and_hold();
    wr(8'h00, 8'h00);
    rd_chk("R11 id unchanged", 8'h00, 8'hA1);
    ev_vmov = 1'b1; @(negedge clk); ev_vmov = 1'b0;
    wr(8'h01, 8'h00);
    rd_chk("R11 summary unchanged", 8'h01, 8'h30);
    wr(8'h0B, 8'h00);
    @(negedge clk);
    chk("R12 rd_data held", {24'd0, rd_data}, 32'h30);
    clear_all();
  endtask

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    ev_vmov = 1'b0; ev_vmuv = 1'b0; ev_ocp = '0; ev_tsd = 1'b0; ev_ola = '0;
    st_itrip = 1'b0; st_active = 1'b0; st_drvoff = 1'b0; st_olp = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clear();
    t_unmapped();
    t_events();
    t_priority();
    t_status();
    t_ovr();
    t_cfg();
    t_ro_and_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule